// File: doc/BRIEF.md
# Predicated Result Selector for a Processing-Element Row

This block sits at the output of a short row of coarse-grain processing elements attached to a RISC core. Each reconfigurable instruction issues once. On that issue the block reduces the results of all elements to one value for the core. It runs in one of two modes. In fixed mode, a configuration index names the element whose result is returned. In predicated mode, the least significant bit of one element's result acts as a comparison flag. The flag chooses between a then-element and an else-element, so a short if-then-else runs without a branch.

Each element is configured as combinational or registered. A combinational source gives its result in the issue cycle. A registered source gives it one cycle later, from a holding stage. In predicated mode the comparison element and both candidate elements count toward the latency, and the slowest of them sets it.

Both data edges use valid/ready. Issue is accepted when `in_valid && in_ready`, and a result leaves when `out_valid && out_ready`. While `in_valid` is high and `in_ready` is low, the upstream side must hold `in_valid`, the element results and every configuration pin unchanged. Once `out_valid` is raised, it stays high with the same data until `out_ready` takes it. At most one registered result is held at a time, and results leave in issue order.

Top module: `pe_row_result_sel`

## Requirements
- R1: While and right after reset, `out_valid` is 0 and no result is held.
- R2: In fixed mode (`cfg_pred_en`=0), `out_data` equals the result of the element indexed by `cfg_fixed_sel`. The then, else and compare indices have no effect.
- R3: In predicated mode (`cfg_pred_en`=1), `out_data` is the `cfg_then_sel` element's result when bit 0 of the `cfg_cmp_sel` element's result is 1. It is the `cfg_else_sel` element's result when that bit is 0.
- R4: When the effective latency is 0, an accepted issue shows `out_valid`=1 with its result in the same cycle.
- R5: When the effective latency is 1, an accepted issue shows `out_valid`=1 from the next cycle on, with the value selected at issue. Element i is registered when bit i of `cfg_reg_mask` is 1.
- R6: In predicated mode, the effective latency is 1 if any of the then, else or compare elements is registered. Otherwise it is 0.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` does not change.
- R8: `in_ready` follows the effective latency of the current issue. At latency 0 it is `!held && out_ready`. At latency 1 it is `!held || out_ready`.
- R9: In fixed mode, the mask bits of elements other than the selected one do not change the latency.
- R10: A held result leaves before any later issue, including one that is accepted in the cycle the held result leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe of a reconfigurable instruction |
| in_ready | output | 1 | Issue may be accepted this cycle |
| pe_results | input | N*W | Element results, element i at bits [i*W +: W] |
| cfg_pred_en | input | 1 | 1 = predicated mode, 0 = fixed mode |
| cfg_fixed_sel | input | log2 N | Source element in fixed mode |
| cfg_then_sel | input | log2 N | Source when the flag is 1 |
| cfg_else_sel | input | log2 N | Source when the flag is 0 |
| cfg_cmp_sel | input | log2 N | Element whose bit 0 is the flag |
| cfg_reg_mask | input | N | Per-element registered (1) or combinational (0) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Core takes the result |
| out_data | output | W | Selected result |

## Verification
The hardest case to reach is a held registered result being taken by the core in the same cycle that a new issue is accepted behind it. A combinational issue waiting behind a stalled held result is just as hard. Both need the holding stage full, `out_ready` changing, and a change of latency between one issue and the next. The bench drives random latency masks, modes and indices with random back-pressure over thousands of cycles. It holds each issue stable until it is accepted, as the protocol requires. A behavioural model predicts ready, valid and data on every cycle.

// File: rtl/osel_pkg.sv
package osel_pkg;
  typedef enum logic [0:0] {
    SRC_COMB = 1'b0,
    SRC_REG  = 1'b1
  } osel_lat_e;

  function automatic osel_lat_e lat_of(input logic bit_reg);
    return bit_reg ? SRC_REG : SRC_COMB;
  endfunction
endpackage

// File: rtl/osel_route.sv
module osel_route
  import osel_pkg::*;
#(
  parameter int W  = 32,
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0] pe_flat,
  input  logic           pred_en,
  input  logic [IW-1:0]  fixed_sel,
  input  logic [IW-1:0]  then_sel,
  input  logic [IW-1:0]  else_sel,
  input  logic [IW-1:0]  cmp_sel,
  input  logic [N-1:0]   reg_mask,
  output logic [W-1:0]   sel_data,
  output osel_lat_e      sel_lat
);
  logic [W-1:0] pe_arr [N];
  logic [N-1:0] flag_vec;

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign pe_arr[g]   = pe_flat[g*W +: W];
    assign flag_vec[g] = pe_flat[g*W];
  end

  logic flag;
  assign flag = flag_vec[cmp_sel];

  always_comb begin
    if (pred_en) begin
      sel_data = flag ? pe_arr[then_sel] : pe_arr[else_sel];
      sel_lat  = lat_of(reg_mask[then_sel] | reg_mask[else_sel] | reg_mask[cmp_sel]);
    end else begin
      sel_data = pe_arr[fixed_sel];
      sel_lat  = lat_of(reg_mask[fixed_sel]);
    end
  end
endmodule

// File: rtl/osel_hold.sv
module osel_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic         held,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b0;
      dout <= '0;
    end else begin
      if (push) begin
        held <= 1'b1;
        dout <= din;
      end else if (pop) begin
        held <= 1'b0;
      end
    end
  end

  assert_push_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (held && dout == $past(din)));

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $fell(rst_n) |=> !held);
endmodule

// File: rtl/pe_row_result_sel.sv
module pe_row_result_sel
  import osel_pkg::*;
#(
  parameter int W  = 32,
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N*W-1:0] pe_results,
  input  logic           cfg_pred_en,
  input  logic [IW-1:0]  cfg_fixed_sel,
  input  logic [IW-1:0]  cfg_then_sel,
  input  logic [IW-1:0]  cfg_else_sel,
  input  logic [IW-1:0]  cfg_cmp_sel,
  input  logic [N-1:0]   cfg_reg_mask,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_data
);
  logic [W-1:0] sel_data;
  osel_lat_e    sel_lat;
  logic         held;
  logic [W-1:0] held_data;
  logic         push, pop, slow;

  osel_route #(.W(W), .N(N)) u_route (
    .pe_flat  (pe_results),
    .pred_en  (cfg_pred_en),
    .fixed_sel(cfg_fixed_sel),
    .then_sel (cfg_then_sel),
    .else_sel (cfg_else_sel),
    .cmp_sel  (cfg_cmp_sel),
    .reg_mask (cfg_reg_mask),
    .sel_data (sel_data),
    .sel_lat  (sel_lat)
  );

  assign slow     = (sel_lat == SRC_REG);
  assign in_ready = slow ? (!held || out_ready) : (!held && out_ready);
  assign pop      = held && out_ready;
  assign push     = in_valid && in_ready && slow;

  osel_hold #(.W(W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push),
    .pop  (pop),
    .din  (sel_data),
    .held (held),
    .dout (held_data)
  );

  assign out_valid = held || (in_valid && !slow);
  assign out_data  = held ? held_data : sel_data;

  assert_fast_same_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !slow) |-> (out_valid && out_ready && out_data == sel_data));

  assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_issue_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !out_ready) |-> !in_ready);

  assert_held_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (out_data == held_data));
endmodule

// File: tb/pe_row_result_sel_tb.sv
module pe_row_result_sel_tb;
  localparam int W = 32;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*W-1:0] pe_results = '0;
  logic cfg_pred_en = 1'b0;
  logic [IW-1:0] cfg_fixed_sel = '0, cfg_then_sel = '0, cfg_else_sel = '0, cfg_cmp_sel = '0;
  logic [N-1:0] cfg_reg_mask = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pe_row_result_sel #(.W(W), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pe_results(pe_results), .cfg_pred_en(cfg_pred_en), .cfg_fixed_sel(cfg_fixed_sel),
    .cfg_then_sel(cfg_then_sel), .cfg_else_sel(cfg_else_sel), .cfg_cmp_sel(cfg_cmp_sel),
    .cfg_reg_mask(cfg_reg_mask), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] pe_val(input int i);
    return pe_results[i*W +: W];
  endfunction

  bit m_held = 0;
  logic [W-1:0] m_hold = '0;

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit accepted = 1;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {31'b0, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {31'b0, out_valid}, 0);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit lat, rdy, vld, others;
      logic [W-1:0] sel;
      @(negedge clk);
      if (accepted || !in_valid) begin
        in_valid = ($urandom_range(3) != 0);
        for (int i = 0; i < N; i++) pe_results[i*W +: W] = $urandom;
        cfg_pred_en   = $urandom_range(1);
        cfg_fixed_sel = $urandom_range(N-1);
        cfg_then_sel  = $urandom_range(N-1);
        cfg_else_sel  = $urandom_range(N-1);
        cfg_cmp_sel   = $urandom_range(N-1);
        cfg_reg_mask  = (cyc < 1000) ? '0 : N'($urandom);
      end
      out_ready = ($urandom_range(2) != 0);
      #1;
      if (cfg_pred_en) begin
        sel = pe_val(cfg_cmp_sel)[0] ? pe_val(cfg_then_sel) : pe_val(cfg_else_sel);
        lat = cfg_reg_mask[cfg_then_sel] | cfg_reg_mask[cfg_else_sel] | cfg_reg_mask[cfg_cmp_sel];
        others = 0;
      end else begin
        sel = pe_val(cfg_fixed_sel);
        lat = cfg_reg_mask[cfg_fixed_sel];
        others = ((cfg_reg_mask & ~(N'(1) << cfg_fixed_sel)) != 0);
      end
      rdy = lat ? (!m_held || out_ready) : (!m_held && out_ready);
      vld = m_held || (in_valid && !lat);
      check("R8 in_ready", {31'b0, in_ready}, {31'b0, rdy});
      if (m_held)
        check(out_ready ? "R5 held valid" : "R7 stalled valid", {31'b0, out_valid}, {31'b0, vld});
      else if (!cfg_pred_en && others && !lat)
        check("R9 fixed-mode latency", {31'b0, out_valid}, {31'b0, vld});
      else if (cfg_pred_en && in_valid)
        check("R6 predicated latency", {31'b0, out_valid}, {31'b0, vld});
      else
        check("R4 out_valid", {31'b0, out_valid}, {31'b0, vld});
      if (vld) begin
        if (m_held)
          check(out_ready ? "R10 held data first" : "R7 stalled data", out_data, m_hold);
        else
          check(cfg_pred_en ? "R3 predicated data" : "R2 fixed data", out_data, sel);
      end
      accepted = in_valid && rdy;
      if (accepted && lat) begin
        m_held = 1;
        m_hold = sel;
      end else if (m_held && out_ready) begin
        m_held = 0;
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule